// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Target

This block is the target side of a 32-bit synchronous bus on which address and data share one set of lines. When a master starts a transaction, the block captures the address and the four command lines. If the address falls inside its single window and the command is a memory or I/O access, it claims the transaction by asserting device-select. It then serves one or more data phases out of a small internal register file. Data phases can be single or a linear burst.

Every bus output is modelled as a value plus a separate drive enable, so a pad ring or a bus model can build the tri-state lines from them. The target inserts a fixed number of wait states before the first data phase and between later phases. On reads it keeps a turnaround clock free on the address/data lines. It drives even parity one clock behind its read data. It checks the parity that the master sends on writes and raises an error flag when that parity is wrong. The control lines all use the bus's active-low convention.

Top module: `mux_bus_target`

## Requirements
- R1: An address phase is the first clock with frame low after a clock in which frame and initiator-ready were both high. If that address phase hits the window (address bits above log2(4*NREGS) equal to those of BASE_ADDR) and the command is claimed, device-select is driven low from the next clock onward. Otherwise device-select, target-ready and the data lines stay undriven.
- R2: The claimed reads are 4'b0010, 4'b0110, 4'b1100 and 4'b1110. The claimed writes are 4'b0011, 4'b0111 and 4'b1111. Every other command is ignored, including 4'b1010 and 4'b1011, and an ignored write leaves the register file unchanged.
- R3: On a read, the target does not drive the data lines in the clock after the address phase. It drives them from the clock after that until the last phase completes. On a write it never drives them.
- R4: The first target-ready appears 1+INIT_WAIT clocks after the address phase on a write, or 2+INIT_WAIT clocks after it on a read. Each later target-ready appears 1+BURST_WAIT clocks after the clock in which the previous phase completed. The first must come within 16 clocks, and later ones within 8.
- R5: A data phase completes only in a clock where initiator-ready and target-ready are both low. While the master holds initiator-ready high, target-ready stays low once asserted.
- R6: On a completed write phase, byte lane k (AD[8k+7:8k]) of the addressed register is updated only when command/byte-enable bit k is 0. An all-ones enable completes the phase without changing anything.
- R7: The register word index starts at address bits [log2(NREGS)+1:2]. It advances by one per completed phase, wrapping modulo NREGS. Read data is the full 32-bit current content of that register.
- R8: A phase completed while frame is high is the last one. In the next clock target-ready and device-select are driven high and the data lines are released. One clock later all of them are released.
- R9: The parity drive enable equals the data drive enable of the previous clock. When it is set, the parity output equals the XOR of the previous clock's data output and command/byte-enable lines, which gives even parity.
- R10: The error flag is high for exactly the single clock that is two clocks after a completed write phase, when the parity received in the clock following that phase differs from the XOR of that phase's data and byte enables. In every other clock it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| frame_n | input | 1 | Master frame, low while the transaction runs |
| irdy_n | input | 1 | Initiator ready, active low |
| ad_in | input | 32 | Address/data lines as received |
| cmd_be | input | 4 | Command in the address phase, active-low byte enables in data phases |
| par_in | input | 1 | Received parity, one clock behind the data it covers |
| ad_out | output | 32 | Read data driven by the target |
| ad_oe | output | 1 | Drive enable for ad_out |
| par_out | output | 1 | Even parity driven by the target |
| par_oe | output | 1 | Drive enable for par_out |
| trdy_n_out | output | 1 | Target ready value, active low |
| trdy_oe | output | 1 | Drive enable for target ready |
| sel_n_out | output | 1 | Device-select value, active low |
| sel_oe | output | 1 | Drive enable for device-select |
| perr_flag | output | 1 | Write data parity error pulse |

## Verification
All sixteen command codes are sent to an in-window address, which separates the seven claimed commands from the ignored ones, configuration codes included. Addresses just below and just above the window separate the hit test from the command test. A sweep of all sixteen byte-enable patterns on single writes, checked by a burst read-back, shows whether each lane is gated on its own bit and in the right position. Bursts that cross the top of the register file, run with master wait states of zero, one and two clocks, separate wrong index wrap, lost data during held target-ready and wrong wait-state counts. Write phases with corrupted parity at different positions in a burst show whether the error flag is tied to the right phase and clock.

// File: rtl/mbt_pkg.sv
package mbt_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_TURN,
    ST_DATA,
    ST_REL
  } tgt_state_e;

  localparam logic [3:0] CMD_IO_RD   = 4'b0010;
  localparam logic [3:0] CMD_IO_WR   = 4'b0011;
  localparam logic [3:0] CMD_MEM_RD  = 4'b0110;
  localparam logic [3:0] CMD_MEM_WR  = 4'b0111;
  localparam logic [3:0] CMD_RD_MULT = 4'b1100;
  localparam logic [3:0] CMD_RD_LINE = 4'b1110;
  localparam logic [3:0] CMD_WR_INV  = 4'b1111;

endpackage

// File: rtl/mbt_decode.sv
module mbt_decode
  import mbt_pkg::*;
#(
  parameter logic [31:0] BASE_ADDR = 32'h0000_1000,
  parameter int          WIN_BITS  = 5,
  localparam int         TAGW      = 32 - WIN_BITS
) (
  input  logic [TAGW-1:0] addr_tag,
  input  logic [3:0]      cmd,
  output logic            claim,
  output logic            is_write
);

  logic hit;
  logic known;

  always_comb begin
    hit      = (addr_tag == BASE_ADDR[31:WIN_BITS]);
    known    = 1'b0;
    is_write = 1'b0;
    case (cmd)
      CMD_IO_RD, CMD_MEM_RD, CMD_RD_MULT, CMD_RD_LINE: known = 1'b1;
      CMD_IO_WR, CMD_MEM_WR, CMD_WR_INV: begin
        known    = 1'b1;
        is_write = 1'b1;
      end
      default: known = 1'b0;
    endcase
    claim = hit && known;
  end

  // R2: configuration codes are never claimed
  always_comb begin
    if (claim) begin
      assert_no_config_claim_R2: assert (cmd[3:1] != 3'b101);
    end
  end

endmodule

// File: rtl/mbt_regfile.sv
module mbt_regfile #(
  parameter int  NREGS = 8,
  parameter int  DW    = 32,
  localparam int IDXW  = $clog2(NREGS),
  localparam int NLANE = DW / 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDXW-1:0]  idx,
  input  logic [NLANE-1:0] lane_en,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata
);

  logic [DW-1:0] words [NREGS];

  for (genvar r = 0; r < NREGS; r++) begin : g_word
    logic [NLANE-1:0][7:0] word_q;
    logic [NLANE-1:0][7:0] word_d;
    logic                  sel;

    always_comb begin
      sel    = wr_en && (idx == IDXW'(r));
      word_d = word_q;
      for (int l = 0; l < NLANE; l++) begin
        if (sel && lane_en[l]) word_d[l] = wdata[8*l +: 8];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   word_q <= '0;
      else if (sel) word_q <= word_d;
    end

    assign words[r] = word_q;
  end

  assign rdata = words[idx];

endmodule

// File: rtl/mbt_parity.sv
module mbt_parity #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] tx_data,
  input  logic          tx_en,
  input  logic [DW-1:0] rx_data,
  input  logic [3:0]    cbe,
  input  logic          rx_par,
  input  logic          chk_en,
  output logic          par_out,
  output logic          par_oe,
  output logic          perr
);

  logic par_q, par_d;
  logic oe_q, oe_d;
  logic exp_q, exp_d;
  logic pend_q, pend_d;
  logic perr_q, perr_d;

  always_comb begin
    par_d  = ^{tx_data, cbe};
    oe_d   = tx_en;
    exp_d  = ^{rx_data, cbe};
    pend_d = chk_en;
    perr_d = pend_q && (rx_par != exp_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      par_q  <= 1'b0;
      oe_q   <= 1'b0;
      exp_q  <= 1'b0;
      pend_q <= 1'b0;
      perr_q <= 1'b0;
    end else begin
      par_q  <= par_d;
      oe_q   <= oe_d;
      exp_q  <= exp_d;
      pend_q <= pend_d;
      perr_q <= perr_d;
    end
  end

  assign par_out = par_q;
  assign par_oe  = oe_q;
  assign perr    = perr_q;

  // R10: the flag only follows a pending write check
  assert_flag_after_check_R10: assert property (@(posedge clk) disable iff (!rst_n)
    perr |-> $past(chk_en, 2));

endmodule

// File: rtl/mux_bus_target.sv
module mux_bus_target
  import mbt_pkg::*;
#(
  parameter logic [31:0] BASE_ADDR  = 32'h0000_1000,
  parameter int          NREGS      = 8,
  parameter int          INIT_WAIT  = 2,
  parameter int          BURST_WAIT = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        frame_n,
  input  logic        irdy_n,
  input  logic [31:0] ad_in,
  input  logic [3:0]  cmd_be,
  input  logic        par_in,
  output logic [31:0] ad_out,
  output logic        ad_oe,
  output logic        par_out,
  output logic        par_oe,
  output logic        trdy_n_out,
  output logic        trdy_oe,
  output logic        sel_n_out,
  output logic        sel_oe,
  output logic        perr_flag
);

  localparam int IDXW     = $clog2(NREGS);
  localparam int WIN_BITS = IDXW + 2;
  localparam int WAIT_MAX = (INIT_WAIT > BURST_WAIT) ? INIT_WAIT : BURST_WAIT;
  localparam int CNTW     = $clog2(WAIT_MAX + 2);

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q, rst_s_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_s_q    <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_s_q    <= rst_meta_q;
    end
  end

  tgt_state_e      state_q, state_d;
  logic [CNTW-1:0] cnt_q, cnt_d;
  logic [IDXW-1:0] widx_q, widx_d;
  logic            wr_q, wr_d;
  logic            idle_q, idle_d;

  logic claim, is_write, addr_phase, trdy_on, done;
  logic [31:0] rdata;

  mbt_decode #(
    .BASE_ADDR (BASE_ADDR),
    .WIN_BITS  (WIN_BITS)
  ) u_decode (
    .addr_tag (ad_in[31:WIN_BITS]),
    .cmd      (cmd_be),
    .claim    (claim),
    .is_write (is_write)
  );

  always_comb begin
    addr_phase = (state_q == ST_IDLE) && idle_q && !frame_n;
    trdy_on    = (state_q == ST_DATA) && (cnt_q == '0);
    done       = trdy_on && !irdy_n;
    idle_d     = frame_n && irdy_n;
    state_d    = state_q;
    cnt_d      = cnt_q;
    widx_d     = widx_q;
    wr_d       = wr_q;
    case (state_q)
      ST_IDLE: begin
        if (addr_phase && claim) begin
          widx_d = ad_in[IDXW+1:2];
          wr_d   = is_write;
          cnt_d  = CNTW'(INIT_WAIT);
          state_d = is_write ? ST_DATA : ST_TURN;
        end
      end
      ST_TURN: begin
        state_d = ST_DATA;
      end
      ST_DATA: begin
        if (cnt_q != '0) begin
          cnt_d = cnt_q - 1'b1;
        end else if (done) begin
          if (frame_n) begin
            state_d = ST_REL;
          end else begin
            widx_d = widx_q + 1'b1;
            cnt_d  = CNTW'(BURST_WAIT);
          end
        end
      end
      ST_REL: begin
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s_q) begin
    if (!rst_s_q) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      widx_q  <= '0;
      wr_q    <= 1'b0;
      idle_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      widx_q  <= widx_d;
      wr_q    <= wr_d;
      idle_q  <= idle_d;
    end
  end

  mbt_regfile #(
    .NREGS (NREGS),
    .DW    (32)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_s_q),
    .wr_en   (done && wr_q),
    .idx     (widx_q),
    .lane_en (~cmd_be),
    .wdata   (ad_in),
    .rdata   (rdata)
  );

  always_comb begin
    sel_oe     = (state_q != ST_IDLE);
    sel_n_out  = (state_q == ST_REL);
    trdy_oe    = (state_q != ST_IDLE);
    trdy_n_out = !trdy_on;
    ad_oe      = (state_q == ST_DATA) && !wr_q;
    ad_out     = rdata;
  end

  mbt_parity #(
    .DW (32)
  ) u_par (
    .clk     (clk),
    .rst_n   (rst_s_q),
    .tx_data (ad_out),
    .tx_en   (ad_oe),
    .rx_data (ad_in),
    .cbe     (cmd_be),
    .rx_par  (par_in),
    .chk_en  (done && wr_q),
    .par_out (par_out),
    .par_oe  (par_oe),
    .perr    (perr_flag)
  );

  // latency window counter used by the R4 check
  logic [4:0] gap_q, gap_d;
  logic       first_q, first_d;
  always_comb begin
    gap_d   = gap_q;
    first_d = first_q;
    if (addr_phase && claim) begin
      gap_d   = 5'd1;
      first_d = 1'b1;
    end else if (done) begin
      gap_d   = 5'd1;
      first_d = 1'b0;
    end else if ((state_q == ST_TURN || state_q == ST_DATA) && !trdy_on && gap_q != 5'd31) begin
      gap_d = gap_q + 5'd1;
    end
  end
  always_ff @(posedge clk or negedge rst_s_q) begin
    if (!rst_s_q) begin
      gap_q   <= '0;
      first_q <= 1'b0;
    end else begin
      gap_q   <= gap_d;
      first_q <= first_d;
    end
  end

  assert_trdy_needs_sel_R1: assert property (@(posedge clk) disable iff (!rst_s_q)
    (trdy_oe && !trdy_n_out) |-> (sel_oe && !sel_n_out));

  assert_read_turnaround_R3: assert property (@(posedge clk) disable iff (!rst_s_q)
    (addr_phase && claim && !is_write) |=> !ad_oe);

  assert_release_high_R8: assert property (@(posedge clk) disable iff (!rst_s_q)
    $fell(sel_oe) |-> $past(sel_n_out && trdy_n_out));

  assert_latency_limit_R4: assert property (@(posedge clk) disable iff (!rst_s_q)
    (state_q == ST_DATA && trdy_on) |-> (first_q ? (gap_q <= 5'd16) : (gap_q <= 5'd8)));

endmodule

// File: tb/sim_mux_bus_target.sv
module sim_mux_bus_target;

  localparam logic [31:0] BASE = 32'h0000_1000;
  localparam int NR = 8;
  localparam int IW = 2;
  localparam int BW = 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_n = 1'b1;
  logic        irdy_n = 1'b1;
  logic [31:0] ad_in = '0;
  logic [3:0]  cmd_be = 4'hF;
  logic        par_in = 1'b0;
  logic [31:0] ad_out;
  logic        ad_oe, par_out, par_oe, trdy_n_out, trdy_oe, sel_n_out, sel_oe, perr_flag;

  always #5 clk = ~clk;

  mux_bus_target #(
    .BASE_ADDR (BASE), .NREGS (NR), .INIT_WAIT (IW), .BURST_WAIT (BW)
  ) u0 (
    .clk (clk), .rst_n (rst_n), .frame_n (frame_n), .irdy_n (irdy_n),
    .ad_in (ad_in), .cmd_be (cmd_be), .par_in (par_in),
    .ad_out (ad_out), .ad_oe (ad_oe), .par_out (par_out), .par_oe (par_oe),
    .trdy_n_out (trdy_n_out), .trdy_oe (trdy_oe), .sel_n_out (sel_n_out),
    .sel_oe (sel_oe), .perr_flag (perr_flag)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;
  logic [31:0] model [NR];
  logic [3:0]  be_tab [8];
  logic [31:0] wd_tab [8];
  logic        prev_ad_oe = 0, prev_inj = 0, inj = 0;
  logic [31:0] prev_ad_out = '0, prev_adin = '0;
  logic [3:0]  prev_cbe = '0;
  logic        perr_pend = 0;
  logic [1:0]  pipe = '0;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic step();
    prev_ad_oe  = ad_oe;
    prev_ad_out = ad_out;
    prev_cbe    = cmd_be;
    prev_adin   = ad_in;
    prev_inj    = inj;
    @(negedge clk);
    par_in    = ^{prev_adin, prev_cbe} ^ prev_inj;
    inj       = 1'b0;
    pipe      = {pipe[0], perr_pend};
    perr_pend = 1'b0;
    chk("R10", "perr_flag", {31'd0, perr_flag}, {31'd0, pipe[1]});
    chk("R9", "par_oe", {31'd0, par_oe}, {31'd0, prev_ad_oe});
    if (prev_ad_oe) chk("R9", "par_out", {31'd0, par_out}, {31'd0, ^{prev_ad_out, prev_cbe}});
  endtask

  task automatic idle(input int n);
    frame_n = 1'b1; irdy_n = 1'b1; cmd_be = 4'hF;
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic txn(input logic [3:0] cmd, input logic [31:0] addr, input int n,
                     input int mw, input int bad_ph);
    bit wr = cmd[0];
    int ph = 0;
    int since = 0;
    int wait_left = mw;
    int idx = int'(addr[4:2]);
    bit first = 1;
    bit seen = 0;
    bit held = 0;
    bit trdy_now;
    frame_n = 1'b0; irdy_n = 1'b1; ad_in = addr; cmd_be = cmd;
    step();
    chk("R1", "sel asserted", {31'd0, sel_oe && !sel_n_out}, 32'd1);
    if (!wr) chk("R3", "turnaround ad_oe", {31'd0, ad_oe}, 32'd0);
    since = 1;
    while (ph < n) begin
      irdy_n  = (wait_left > 0);
      frame_n = (ph == n - 1) && (wait_left == 0);
      cmd_be  = be_tab[ph];
      ad_in   = wr ? wd_tab[ph] : (32'h5A5A_0000 | ph);
      inj     = wr && (ph == bad_ph);
      trdy_now = trdy_oe && !trdy_n_out;
      if (held) chk("R5", "trdy held", {31'd0, trdy_now}, 32'd1);
      if (trdy_now && !seen) begin
        chk("R4", "trdy delay", since, first ? ((wr ? 1 : 2) + IW) : (1 + BW));
        seen = 1;
      end
      if (wr) chk("R3", "write ad_oe", {31'd0, ad_oe}, 32'd0);
      else if (!(first && since == 1)) chk("R3", "read ad_oe", {31'd0, ad_oe}, 32'd1);
      held = trdy_now && irdy_n;
      if (trdy_now && !irdy_n) begin
        if (wr) begin
          for (int l = 0; l < 4; l++)
            if (!cmd_be[l]) model[idx][8*l +: 8] = ad_in[8*l +: 8];
          if (ph == bad_ph) perr_pend = 1'b1;
        end else begin
          chk("R7", "read data", ad_out, model[idx]);
        end
        idx = (idx + 1) % NR;
        ph++;
        first = 0; seen = 0; since = 0; wait_left = mw;
      end else if (wait_left > 0) begin
        wait_left--;
      end
      step();
      since++;
    end
    chk("R8", "rel trdy", {30'd0, trdy_oe, trdy_n_out}, 32'd3);
    chk("R8", "rel sel", {30'd0, sel_oe, sel_n_out}, 32'd3);
    chk("R8", "rel ad_oe", {31'd0, ad_oe}, 32'd0);
    frame_n = 1'b1; irdy_n = 1'b1; cmd_be = 4'hF;
    step();
    chk("R8", "released", {30'd0, trdy_oe, sel_oe}, 32'd0);
    step();
  endtask

  task automatic no_claim(input logic [3:0] cmd, input logic [31:0] addr, input string req);
    frame_n = 1'b0; irdy_n = 1'b1; ad_in = addr; cmd_be = cmd;
    step();
    frame_n = 1'b1; irdy_n = 1'b0; cmd_be = 4'h0; ad_in = 32'hFFFF_FFFF;
    for (int i = 0; i < 4; i++) begin
      chk(req, "no drive", {29'd0, sel_oe, trdy_oe, ad_oe}, 32'd0);
      step();
    end
    idle(2);
  endtask

  initial begin
    for (int i = 0; i < NR; i++) model[i] = '0;
    for (int i = 0; i < 8; i++) begin be_tab[i] = 4'h0; wd_tab[i] = '0; end
    repeat (3) @(negedge clk);
    chk("R8", "reset outputs", {27'd0, sel_oe, trdy_oe, ad_oe, par_oe, perr_flag}, 32'd0);
    rst_n = 1'b1;
    idle(4);

    // R2: every command code at an in-window address
    for (int c = 0; c < 16; c++) begin
      logic [3:0] cc = 4'(c);
      if (cc inside {4'b0010, 4'b0110, 4'b1100, 4'b1110, 4'b0011, 4'b0111, 4'b1111}) begin
        be_tab[0] = 4'h0; wd_tab[0] = 32'hC0DE_0000 | c;
        txn(cc, BASE + 32'(4 * (c % NR)), 1, 0, -1);
      end else begin
        no_claim(cc, BASE + 32'(4 * (c % NR)), "R2");
      end
    end
    // R1: just outside the window on both sides
    no_claim(4'b0111, BASE - 32'd4, "R1");
    no_claim(4'b0110, BASE + 32'd32, "R1");

    // R6: every byte-enable pattern
    for (int b = 0; b < 16; b++) begin
      be_tab[0] = 4'(b); wd_tab[0] = 32'h1122_3344 ^ (32'(b) * 32'h0101_0101);
      txn(4'b0111, BASE + 32'(4 * (b % NR)), 1, 0, -1);
    end
    for (int i = 0; i < 8; i++) be_tab[i] = 4'h0;
    txn(4'b1100, BASE, 8, 0, -1);

    // R5 R7: wrapping bursts with master wait states
    for (int mw = 0; mw < 3; mw++) begin
      for (int p = 0; p < 4; p++) begin
        wd_tab[p] = 32'hA000_0000 | (mw << 8) | p;
        be_tab[p] = (p == 2) ? 4'b1010 : 4'b0000;
      end
      txn(4'b1111, BASE + 32'd24, 4, mw, -1);
      for (int i = 0; i < 8; i++) be_tab[i] = 4'h0;
      txn(4'b1110, BASE + 32'd20, 8, mw, -1);
    end

    // R10: corrupted parity on chosen write phases
    for (int p = 0; p < 3; p++) wd_tab[p] = 32'hBEEF_0000 | p;
    txn(4'b0011, BASE + 32'd8, 3, 0, 1);
    txn(4'b0111, BASE + 32'd28, 2, 2, 0);
    txn(4'b0111, BASE + 32'd4, 3, 1, 2);
    txn(4'b0010, BASE, 8, 0, -1);
    idle(3);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule